// File: doc/BRIEF.md
# Interlace-Aware Raster Frame Timer

This block tracks where a raster scan stands in the vertical direction. A line sequencer outside the block raises a one-cycle end-of-line strobe. On each strobe the block moves its line counter forward, wraps it at the end of the frame and flips a field parity bit on every wrap. It also loads the length of the line that follows, in master cycles, and gives the line position at which work memory is refreshed. The outside sequencer reads these values to schedule the next line.

Frame length depends on interlace. When interlace is enabled and the field that is starting has even parity, the frame gets one extra line. The line counter runs in the same clock cycle as the line events, so vertical blanking entry, the interrupt request that may go with it and the controller auto-read trigger are all decoded from the line number being entered. On non-interlaced odd fields, line 240 loses one dot. On the second chip revision, the refresh position moves between two values from one line to the next. The short line breaks that alternation.

An asserted `nmi_sched` tells the sequencer to raise the non-maskable interrupt 12 master cycles into the line that follows. The block exposes `NMI_OFFSET` as a parameter with that value.

Top module: `frame_timer`

## Requirements
- R1: After reset the block shows line 0 with even field parity (`field_odd`=0). The line length is 1364, the refresh position is 534 (with `rev2`=1), the vblank flag is clear and both strobes are low.
- R2: Each cycle with `line_end` high moves `vline` up by one, and the new value is visible one clock later. While `line_end` stays low, every output holds.
- R3: When the increment would reach the current frame line count, `vline` returns to 0 and `field_odd` flips.
- R4: The frame line count is 262 plus one when interlace is enabled at the wrap and the new field is even (`field_odd`=0). Otherwise it is 262. The count that applies after reset is 262.
- R5: A line lasts 341 dots of 4 cycles, giving 1364. When the line being entered is 240, interlace is off and `field_odd`=1, `line_cycles` is 1360.
- R6: `nmi_status` bit 7 is the vblank flag. It sets on entry to line 225, or line 240 when `tall_screen`=1, and clears on the frame wrap. Bits 6..2 are 0. Bits 1..0 hold the revision code: 2'b10 when `rev2`=1 and 2'b01 otherwise.
- R7: `nmi_sched` pulses for one cycle on entry to the vblank line, but only when `nmi_en` is 1.
- R8: `pad_trig` pulses for one cycle on entry to line 227, or line 242 when `tall_screen`=1, but only when `autopad_en` is 1.
- R9: With `rev2`=1, `refresh_pos` moves between 534 and 538 on each line, starting from 534. On a short line it keeps its value. With `rev2`=0 it is fixed at 538.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | One-cycle end-of-line strobe |
| interlace_en | input | 1 | Interlaced scan enable |
| nmi_en | input | 1 | Allows an interrupt request at vblank entry |
| autopad_en | input | 1 | Allows the controller auto-read trigger |
| tall_screen | input | 1 | 1 selects 239 visible lines, 0 selects 224 |
| rev2 | input | 1 | Second chip revision select |
| vline | output | 9 | Current line number |
| field_odd | output | 1 | Field parity |
| line_cycles | output | 11 | Length of the current line in master cycles |
| refresh_pos | output | 10 | Memory-refresh position within the line |
| nmi_status | output | 8 | Vblank flag in bit 7, revision code in bits 1..0 |
| nmi_sched | output | 1 | Interrupt schedule strobe |
| pad_trig | output | 1 | Controller auto-read strobe |

## Verification
The short line is the hardest case to reach from the ports. It appears only on line 240 of an odd field with interlace off, so the stimulus has to run a full 262-line frame before that line can occur. The same odd field also breaks the refresh alternation, which is checked there. The 263-line frame needs interlace enabled across two wraps: the first wrap moves to the odd field, and only the wrap back to the even field lengthens the frame. The bench compares every output on every line against its own model while it walks through these frames.

// File: rtl/ft_pkg.sv
package ft_pkg;
  parameter int unsigned VLINE_W = 9;
  typedef logic [VLINE_W-1:0] vline_t;

  // line being entered on the current strobe
  typedef struct packed {
    vline_t line;
    logic   field;
    logic   wrap;
    logic   short_line;
  } step_t;
endpackage

// File: rtl/ft_line_count.sv
module ft_line_count
  import ft_pkg::*;
#(
  parameter int unsigned BASE_LINES = 262,
  parameter int unsigned SHORT_LINE = 240
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_end,
  input  logic   interlace_en,
  output vline_t vline,
  output logic   field,
  output step_t  nxt
);
  localparam vline_t BASE_V = vline_t'(BASE_LINES);
  localparam vline_t LONG_V = vline_t'(BASE_LINES + 1);
  localparam vline_t SHORT_V = vline_t'(SHORT_LINE);

  vline_t vmax_q;
  vline_t vmax_d;
  vline_t inc;

  always_comb begin
    inc            = vline + vline_t'(1);
    nxt.wrap       = (inc >= vmax_q);
    nxt.line       = nxt.wrap ? '0 : inc;
    nxt.field      = field ^ nxt.wrap;
    nxt.short_line = (nxt.line == SHORT_V) && !interlace_en && nxt.field;
    vmax_d         = vmax_q;
    if (nxt.wrap) vmax_d = (interlace_en && !nxt.field) ? LONG_V : BASE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vline  <= '0;
      field  <= 1'b0;
      vmax_q <= BASE_V;
    end else if (line_end) begin
      vline  <= nxt.line;
      field  <= nxt.field;
      vmax_q <= vmax_d;
    end
  end
endmodule

// File: rtl/ft_line_shape.sv
module ft_line_shape
  import ft_pkg::*;
#(
  parameter int unsigned DOT_CYCLES    = 4,
  parameter int unsigned LINE_DOTS     = 341,
  parameter int unsigned LEN_W         = 11,
  parameter int unsigned REF_W         = 10,
  parameter int unsigned REFRESH_LO    = 534,
  parameter int unsigned REFRESH_FIXED = 538
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             rev2,
  input  step_t            nxt,
  output logic [LEN_W-1:0] line_cycles,
  output logic [REF_W-1:0] refresh_pos
);
  localparam logic [LEN_W-1:0] FULL_LEN  = LEN_W'(DOT_CYCLES * LINE_DOTS);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(DOT_CYCLES * (LINE_DOTS - 1));
  localparam logic [REF_W-1:0] REF_A     = REF_W'(REFRESH_LO);
  localparam logic [REF_W-1:0] REF_B     = REF_W'(REFRESH_LO + DOT_CYCLES);
  localparam logic [REF_W-1:0] REF_F     = REF_W'(REFRESH_FIXED);

  logic [LEN_W-1:0] len_d;
  logic             alt_q;
  logic             alt_d;

  always_comb begin
    len_d = nxt.short_line ? SHORT_LEN : FULL_LEN;
    alt_d = (rev2 && !nxt.short_line) ? !alt_q : alt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cycles <= FULL_LEN;
      alt_q       <= 1'b0;
    end else if (line_end) begin
      line_cycles <= len_d;
      alt_q       <= alt_d;
    end
  end

  always_comb begin
    if (!rev2)      refresh_pos = REF_F;
    else if (alt_q) refresh_pos = REF_B;
    else            refresh_pos = REF_A;
  end
endmodule

// File: rtl/ft_events.sv
module ft_events
  import ft_pkg::*;
#(
  parameter int unsigned LINES_SHORT = 224,
  parameter int unsigned LINES_TALL  = 239,
  parameter int unsigned FIRST_LINE  = 1,
  parameter int unsigned PAD_AFTER   = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_end,
  input  logic  tall_screen,
  input  logic  nmi_en,
  input  logic  autopad_en,
  input  step_t nxt,
  output logic  vblank,
  output logic  nmi_sched,
  output logic  pad_trig
);
  vline_t height;
  logic   vbl_hit;
  logic   pad_hit;
  logic   vblank_d;
  logic   nmi_d;
  logic   pad_d;

  always_comb begin
    height   = tall_screen ? vline_t'(LINES_TALL) : vline_t'(LINES_SHORT);
    vbl_hit  = (nxt.line == height + vline_t'(FIRST_LINE));
    pad_hit  = (nxt.line == height + vline_t'(PAD_AFTER));
    vblank_d = vblank;
    if (line_end) begin
      if (nxt.wrap)    vblank_d = 1'b0;
      else if (vbl_hit) vblank_d = 1'b1;
    end
    nmi_d = line_end && vbl_hit && nmi_en;
    pad_d = line_end && pad_hit && autopad_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vblank    <= 1'b0;
      nmi_sched <= 1'b0;
      pad_trig  <= 1'b0;
    end else begin
      vblank    <= vblank_d;
      nmi_sched <= nmi_d;
      pad_trig  <= pad_d;
    end
  end
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import ft_pkg::*;
#(
  parameter int unsigned BASE_LINES    = 262,
  parameter int unsigned SHORT_LINE    = 240,
  parameter int unsigned DOT_CYCLES    = 4,
  parameter int unsigned LINE_DOTS     = 341,
  parameter int unsigned LEN_W         = 11,
  parameter int unsigned REF_W         = 10,
  parameter int unsigned REFRESH_LO    = 534,
  parameter int unsigned REFRESH_FIXED = 538,
  parameter int unsigned LINES_SHORT   = 224,
  parameter int unsigned LINES_TALL    = 239,
  parameter int unsigned NMI_OFFSET    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             interlace_en,
  input  logic             nmi_en,
  input  logic             autopad_en,
  input  logic             tall_screen,
  input  logic             rev2,
  output logic [8:0]       vline,
  output logic             field_odd,
  output logic [LEN_W-1:0] line_cycles,
  output logic [REF_W-1:0] refresh_pos,
  output logic [7:0]       nmi_status,
  output logic             nmi_sched,
  output logic             pad_trig
);
  localparam int unsigned SCHED_AT = NMI_OFFSET;

  step_t  nxt;
  vline_t v_q;
  logic   vblank;

  ft_line_count #(.BASE_LINES(BASE_LINES), .SHORT_LINE(SHORT_LINE)) i_count (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .interlace_en(interlace_en),
    .vline(v_q), .field(field_odd), .nxt(nxt)
  );

  ft_line_shape #(
    .DOT_CYCLES(DOT_CYCLES), .LINE_DOTS(LINE_DOTS), .LEN_W(LEN_W), .REF_W(REF_W),
    .REFRESH_LO(REFRESH_LO), .REFRESH_FIXED(REFRESH_FIXED)
  ) i_shape (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .rev2(rev2), .nxt(nxt),
    .line_cycles(line_cycles), .refresh_pos(refresh_pos)
  );

  ft_events #(.LINES_SHORT(LINES_SHORT), .LINES_TALL(LINES_TALL)) i_events (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .tall_screen(tall_screen),
    .nmi_en(nmi_en), .autopad_en(autopad_en), .nxt(nxt),
    .vblank(vblank), .nmi_sched(nmi_sched), .pad_trig(pad_trig)
  );

  assign vline      = 9'(v_q);
  assign nmi_status = {vblank, 5'b00000, rev2 ? 2'b10 : 2'b01};
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int unsigned BASE_LINES = 262,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned REF_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_end,
  input logic             rev2,
  input logic             interlace_en,
  input logic [8:0]       vline,
  input logic             field_odd,
  input logic [LEN_W-1:0] line_cycles,
  input logic [REF_W-1:0] refresh_pos,
  input logic [7:0]       nmi_status,
  input logic             nmi_sched,
  input logic             pad_trig
);
  // R2
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vline));
  // R3
  field_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd) |-> (vline == 9'd0));
  // R4
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vline <= 9'(BASE_LINES));
  // R5
  short_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycles != 11'd1364) |-> (line_cycles == 11'd1360 && vline == 9'd240 && field_odd));
  // R7
  nmi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_sched |-> nmi_status[7]);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({nmi_sched, pad_trig}) <= 1);
  // R9
  refresh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev2 |-> (refresh_pos == 10'd534 || refresh_pos == 10'd538));
endmodule

bind frame_timer ft_checker #(.BASE_LINES(BASE_LINES), .LEN_W(LEN_W), .REF_W(REF_W)) i_ft_checker (
  .clk(clk), .rst_n(rst_n), .line_end(line_end), .rev2(rev2), .interlace_en(interlace_en),
  .vline(vline), .field_odd(field_odd), .line_cycles(line_cycles), .refresh_pos(refresh_pos),
  .nmi_status(nmi_status), .nmi_sched(nmi_sched), .pad_trig(pad_trig)
);

// File: tb/test_frame_timer.sv
`timescale 1ns/1ps
module test_frame_timer;
  logic clk = 1'b0;
  logic rst_n, line_end, interlace_en, nmi_en, autopad_en, tall_screen, rev2;
  logic [8:0]  vline;
  logic        field_odd;
  logic [10:0] line_cycles;
  logic [9:0]  refresh_pos;
  logic [7:0]  nmi_status;
  logic        nmi_sched, pad_trig;

  int total = 0;
  int fails = 0;

  // model state
  int mv, mf, mvmax, mlen, malt, mvbl, mnmi, mpad;

  always #2 clk = ~clk;

  frame_timer i_frame_timer (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .interlace_en(interlace_en),
    .nmi_en(nmi_en), .autopad_en(autopad_en), .tall_screen(tall_screen), .rev2(rev2),
    .vline(vline), .field_odd(field_odd), .line_cycles(line_cycles),
    .refresh_pos(refresh_pos), .nmi_status(nmi_status), .nmi_sched(nmi_sched),
    .pad_trig(pad_trig)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (line %0d)", req, act, exp, mv);
    end
  endtask

  function automatic int ref_pos();
    if (!rev2) return 538;
    return malt ? 538 : 534;
  endfunction

  function automatic int stat_exp();
    return (mvbl ? 128 : 0) + (rev2 ? 2 : 1);
  endfunction

  task automatic compare_all(input string tag);
    chk({tag, " R2 vline"}, vline, mv);
    chk({tag, " R3 field"}, field_odd, mf);
    chk({tag, " R5 length"}, line_cycles, mlen);
    chk({tag, " R9 refresh"}, refresh_pos, ref_pos());
    chk({tag, " R6 status"}, nmi_status, stat_exp());
    chk({tag, " R7 nmi"}, nmi_sched, mnmi);
    chk({tag, " R8 pad"}, pad_trig, mpad);
  endtask

  task automatic model_step();
    int inc, h;
    bit wrap, shrt;
    inc  = mv + 1;
    wrap = (inc >= mvmax);
    mv   = wrap ? 0 : inc;
    mf   = mf ^ int'(wrap);
    if (wrap) mvmax = (interlace_en && mf == 0) ? 263 : 262;
    shrt = (mv == 240) && !interlace_en && (mf == 1);
    mlen = shrt ? 1360 : 1364;
    if (rev2 && !shrt) malt ^= 1;
    h = tall_screen ? 239 : 224;
    if (wrap) mvbl = 0;
    else if (mv == h + 1) mvbl = 1;
    mnmi = (nmi_en && mv == h + 1) ? 1 : 0;
    mpad = (autopad_en && mv == h + 3) ? 1 : 0;
  endtask

  task automatic step(input string tag);
    model_step();
    @(negedge clk) line_end = 1'b1;
    @(negedge clk) line_end = 1'b0;
    compare_all(tag);
  endtask

  task automatic run_lines(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_end = 1'b0; interlace_en = 1'b0; nmi_en = 1'b1;
    autopad_en = 1'b1; tall_screen = 1'b0; rev2 = 1'b1;
    mv = 0; mf = 0; mvmax = 262; mlen = 1364; malt = 0; mvbl = 0; mnmi = 0; mpad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vline", vline, 0);
    chk("R1 field", field_odd, 0);
    chk("R1 length", line_cycles, 1364);
    chk("R1 refresh", refresh_pos, 534);
    chk("R1 status", nmi_status, 8'h02);
    chk("R1 strobes", {nmi_sched, pad_trig}, 0);
  endtask

  task automatic t_hold();
    run_lines(3, "hold");
    repeat (6) @(negedge clk);
    chk("R2 hold vline", vline, 3);
    chk("R2 hold length", line_cycles, 1364);
    chk("R9 hold refresh", refresh_pos, 538);
  endtask

  task automatic t_progressive();
    run_lines(221, "prog");
    step("vbl");
    chk("R6 vblank set at 225", nmi_status[7], 1);
    chk("R7 nmi pulse at 225", nmi_sched, 1);
    step("post");
    chk("R7 nmi single cycle", nmi_sched, 0);
    step("pad");
    chk("R8 pad at 227", pad_trig, 1);
    run_lines(262 - 227, "prog");
    chk("R3 wrap to 0", vline, 0);
    chk("R3 odd field", field_odd, 1);
    chk("R6 flag cleared on wrap", nmi_status[7], 0);
    run_lines(240, "odd");
    chk("R5 short line 240", line_cycles, 1360);
    step("after240");
    chk("R5 line 241 full", line_cycles, 1364);
    run_lines(262 - 241, "odd");
    chk("R3 back to even", field_odd, 0);
  endtask

  task automatic t_interlace();
    interlace_en = 1'b1;
    run_lines(262, "il0");
    chk("R4 odd frame wrap at 262", vline, 0);
    run_lines(240, "il1");
    chk("R5 no short line interlaced", line_cycles, 1364);
    run_lines(22, "il1");
    chk("R4 even field entered", field_odd, 0);
    run_lines(262, "il2");
    chk("R4 extra line 262", vline, 262);
    step("il2");
    chk("R4 wrap after 263", vline, 0);
    interlace_en = 1'b0;
  endtask

  task automatic t_tall_rev1();
    tall_screen = 1'b1; rev2 = 1'b0; nmi_en = 1'b0; autopad_en = 1'b1;
    run_lines(240, "tall");
    chk("R6 vblank at 240 tall", nmi_status[7], 1);
    chk("R6 rev1 code", nmi_status[1:0], 1);
    chk("R7 nmi masked", nmi_sched, 0);
    chk("R9 rev1 fixed", refresh_pos, 538);
    run_lines(2, "tall");
    chk("R8 pad at 242 tall", pad_trig, 1);
    autopad_en = 1'b0;
    run_lines(20, "tall");
    run_lines(245, "tall2");
    chk("R8 pad masked", pad_trig, 0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_progressive();
    t_interlace();
    t_tall_rev1();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule